// File: doc/BRIEF.md
# Operand Cache Tag Array Controller

This block keeps the per-line tag, valid flag and dirty flag of a direct-mapped operand cache and lets software reach that state as a memory-mapped address array. A read returns the stored tag word of the selected line. A write replaces it. When the write is flagged associative and the line it displaces is both valid and dirty, the block first asks external memory to accept a burst write-back of the old line. Only after memory acknowledges that burst does it store the new tag and complete the access.

A one-cycle invalidate strobe from the cache control register drops the valid and dirty flags of every line and keeps the tag bits. The block visits one line per clock. It raises `busy` for the whole walk and holds off port accesses until the walk ends. The requester drives the line index and the associative flag, which are bits 13..5 and bit 3 of the array address. It holds `acc_req` until `acc_ack` pulses.

Top module: `oc_tag_ctrl`

## Requirements
- R1: The line is selected by `acc_line` (address bits 13..5, 512 lines by default). A read (`acc_we`=0) presents the stored tag word of that line on `acc_rdata` while `acc_ack` is high. Writes to one line leave the word of every other line unchanged.
- R2: A write stores `acc_wdata & 0x1FFFFC03`. The stored word carries physical tag bits 28..10, dirty at bit 1 and valid at bit 0. Every other bit reads back as zero.
- R3: A write with `acc_assoc`=0 replaces the tag directly and never raises `wb_req`, even when the line is valid and dirty.
- R4: A write with `acc_assoc`=1 to a line whose stored valid and dirty bits are both 1 raises `wb_req` before any update. `wb_addr` is the old word's bits 28..10 with bits 9..5 equal to the low five line-index bits and all other bits zero. `wb_index` is the full line index. Both stay stable while `wb_req` is high.
- R5: During a write-back, the tag update and `acc_ack` wait for `wb_ack`. In the cycle after `wb_ack` is sampled, `acc_ack` is high, `wb_req` is low and the new word is stored.
- R6: A write with `acc_assoc`=1 to a line that is not both valid and dirty (flags 00, 01 or 10) stores the new word without a write-back.
- R7: An `inv_strobe` pulse clears the valid and dirty bits of every line. The tag bits 28..10 are kept and no write-back is requested.
- R8: From the cycle after the strobe, `busy` stays high for exactly 2^INDEX_W + 1 cycles, one cycle to start plus one line per clock. A port request made in that time is acknowledged only after `busy` has dropped.
- R9: After reset every line reads with valid and dirty both 0, and `busy`, `wb_req` and `acc_ack` are low.
- R10: Each access produces exactly one single-cycle `acc_ack` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Access request, held until `acc_ack` |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_assoc | input | 1 | Associative write flag (address bit 3) |
| acc_line | input | INDEX_W | Line index (address bits 13..5) |
| acc_wdata | input | 32 | Tag word to write |
| acc_rdata | output | 32 | Tag word read, valid with `acc_ack` |
| acc_ack | output | 1 | One-cycle access completion pulse |
| wb_req | output | 1 | Burst write-back request |
| wb_ack | input | 1 | Write-back accepted by memory |
| wb_addr | output | 32 | Line address of the victim being written back |
| wb_index | output | INDEX_W | Cache line index of the victim |
| inv_strobe | input | 1 | Whole-array invalidate pulse |
| busy | output | 1 | Invalidate pending or walk in progress |

## Verification
The assertions watch the handshakes on every cycle. They check that `acc_ack` is a one-cycle pulse, that `wb_req` and its address hold steady until acknowledged, and that no completion slips out while a write-back is outstanding. They also check that a write-back only ever starts from an associative write outside an invalidate, and that a strobe always raises `busy`. The stored contents can only be shown by the bench's scenarios: the masking of written words, the victim address composition, the flags cleared with the tags kept, the exact walk length and the stall of a request queued behind it.

// File: rtl/oc_tag_pkg.sv
// Package: shared constants and types for the operand cache tag controller.
// Assumes a 32-bit tag word with tag bits 28..10, dirty at bit 1, valid at bit 0.
package oc_tag_pkg;
    localparam int WORD_W    = 32;
    localparam int LINE_LOG2 = 5;
    localparam int TAG_LO    = 10;
    localparam int TAG_HI    = 28;
    localparam int TAG_W     = TAG_HI - TAG_LO + 1;
    localparam int DIRTY_BIT = 1;
    localparam int VALID_BIT = 0;
    localparam logic [WORD_W-1:0] TAG_MASK = 32'h1FFF_FC03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WB,
        ST_DONE,
        ST_INV
    } oc_state_e;
endpackage

// File: rtl/oc_tag_store.sv
// Module: tag, valid and dirty storage for 2^INDEX_W lines.
// One combinational read port, one write port and one flag-clear port.
// Assumes the write and clear ports are never active in the same cycle.
module oc_tag_store
    import oc_tag_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INDEX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0]   rd_word,
    input  logic                wr_en,
    input  logic [INDEX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic                clr_en,
    input  logic [INDEX_W-1:0]  clr_idx
);
    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Tag bits: written on a port write, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_word[TAG_HI:TAG_LO];
    end

    // Flags: reset to invalid and clean, set by writes, cleared by the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (clr_en) begin
            valid_q[clr_idx] <= 1'b0;
            dirty_q[clr_idx] <= 1'b0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_word[VALID_BIT];
            dirty_q[wr_idx] <= wr_word[DIRTY_BIT];
        end
    end

    // Read: assemble the tag word of the addressed line.
    always_comb begin
        rd_word                = '0;
        rd_word[TAG_HI:TAG_LO] = tag_q[rd_idx];
        rd_word[DIRTY_BIT]     = dirty_q[rd_idx];
        rd_word[VALID_BIT]     = valid_q[rd_idx];
    end
endmodule

// File: rtl/oc_tag_seq.sv
// Module: access sequencer. Serves reads and writes, runs the victim
// write-back handshake and walks the array on an invalidate.
// Assumes the requester holds its request fields stable until acc_ack.
module oc_tag_seq
    import oc_tag_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_req,
    input  logic                acc_we,
    input  logic                acc_assoc,
    input  logic [INDEX_W-1:0]  acc_line,
    input  logic [WORD_W-1:0]   acc_wdata,
    output logic [WORD_W-1:0]   acc_rdata,
    output logic                acc_ack,
    output logic                wb_req,
    input  logic                wb_ack,
    output logic [WORD_W-1:0]   wb_addr,
    output logic [INDEX_W-1:0]  wb_index,
    input  logic                inv_strobe,
    output logic                busy,
    input  logic [WORD_W-1:0]   rd_word,
    output logic                wr_en,
    output logic [INDEX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0]   wr_word,
    output logic                clr_en,
    output logic [INDEX_W-1:0]  clr_idx
);
    localparam int OFS_W = TAG_LO - LINE_LOG2;
    localparam logic [WORD_W-1:0] TAG_ONLY = TAG_MASK & ~WORD_W'(3);

    oc_state_e            state_q;
    logic                 pend_q;
    logic [INDEX_W-1:0]   cnt_q;
    logic [INDEX_W-1:0]   hold_idx_q;
    logic [WORD_W-1:0]    hold_data_q;
    logic                 victim_dirty;
    logic                 accept;
    logic [WORD_W-1:0]    victim_addr;

    // Decode: is the addressed line a dirty victim, and may a request start.
    always_comb begin
        victim_dirty = rd_word[VALID_BIT] & rd_word[DIRTY_BIT];
        accept       = (state_q == ST_IDLE) && !pend_q && acc_req;
        victim_addr  = rd_word & TAG_ONLY;
        victim_addr[TAG_LO-1:LINE_LOG2] = acc_line[OFS_W-1:0];
    end

    // Store control: direct writes, post-write-back writes and walk clears.
    always_comb begin
        wr_en   = (accept && acc_we && !(acc_assoc && victim_dirty))
                || (state_q == ST_WB && wb_ack);
        wr_idx  = (state_q == ST_WB) ? hold_idx_q : acc_line;
        wr_word = ((state_q == ST_WB) ? hold_data_q : acc_wdata) & TAG_MASK;
        clr_en  = (state_q == ST_INV);
        clr_idx = cnt_q;
        busy    = pend_q || (state_q == ST_INV);
    end

    // Sequencer: access, write-back and invalidate-walk control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_q      <= 1'b0;
            cnt_q       <= '0;
            hold_idx_q  <= '0;
            hold_data_q <= '0;
            acc_rdata   <= '0;
            acc_ack     <= 1'b0;
            wb_req      <= 1'b0;
            wb_addr     <= '0;
            wb_index    <= '0;
        end else begin
            acc_ack <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        pend_q  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_INV;
                    end else if (acc_req) begin
                        if (!acc_we) begin
                            acc_rdata <= rd_word;
                            acc_ack   <= 1'b1;
                            state_q   <= ST_DONE;
                        end else if (acc_assoc && victim_dirty) begin
                            wb_req      <= 1'b1;
                            wb_addr     <= victim_addr;
                            wb_index    <= acc_line;
                            hold_idx_q  <= acc_line;
                            hold_data_q <= acc_wdata;
                            state_q     <= ST_WB;
                        end else begin
                            acc_ack <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_ack) begin
                        wb_req  <= 1'b0;
                        acc_ack <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                ST_INV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (&cnt_q) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (inv_strobe) pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/oc_tag_ctrl.sv
// Module: top of the operand cache tag array controller.
// Joins the tag store and the access sequencer.
// Assumes INDEX_W >= 5 so that line-address bits 9..5 come from the index.
module oc_tag_ctrl
    import oc_tag_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_req,
    input  logic                acc_we,
    input  logic                acc_assoc,
    input  logic [INDEX_W-1:0]  acc_line,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    output logic                acc_ack,
    output logic                wb_req,
    input  logic                wb_ack,
    output logic [31:0]         wb_addr,
    output logic [INDEX_W-1:0]  wb_index,
    input  logic                inv_strobe,
    output logic                busy
);
    logic [WORD_W-1:0]  rd_word;
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    logic [WORD_W-1:0]  wr_word;
    logic               clr_en;
    logic [INDEX_W-1:0] clr_idx;

    oc_tag_store #(.INDEX_W(INDEX_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (acc_line),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    oc_tag_seq #(.INDEX_W(INDEX_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_we     (acc_we),
        .acc_assoc  (acc_assoc),
        .acc_line   (acc_line),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .acc_ack    (acc_ack),
        .wb_req     (wb_req),
        .wb_ack     (wb_ack),
        .wb_addr    (wb_addr),
        .wb_index   (wb_index),
        .inv_strobe (inv_strobe),
        .busy       (busy),
        .rd_word    (rd_word),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );
endmodule

// File: rtl/oc_tag_chk.sv
// Module: protocol checker bound to oc_tag_ctrl. Observes ports only.
module oc_tag_chk #(
    parameter int INDEX_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_req,
    input logic                acc_we,
    input logic                acc_assoc,
    input logic                acc_ack,
    input logic                wb_req,
    input logic                wb_ack,
    input logic [31:0]         wb_addr,
    input logic [INDEX_W-1:0]  wb_index,
    input logic                inv_strobe,
    input logic                busy
);
    // R10: completion is a single-cycle pulse.
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);

    // R4: request and victim address hold until acknowledged.
    p_wb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_index)));

    // R5: no completion while a write-back is still outstanding.
    p_no_ack_in_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |-> !acc_ack);

    // R3: a write-back only starts from an associative write.
    p_wb_only_assoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(acc_req && acc_we && acc_assoc));

    // R7: no write-back is started while an invalidate is pending or walking.
    p_no_wb_from_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> !$past(busy));

    // R8: a strobe always makes the block busy in the next cycle.
    p_inv_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_strobe |=> busy);
endmodule

bind oc_tag_ctrl oc_tag_chk #(.INDEX_W(INDEX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .acc_we     (acc_we),
    .acc_assoc  (acc_assoc),
    .acc_ack    (acc_ack),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .wb_addr    (wb_addr),
    .wb_index   (wb_index),
    .inv_strobe (inv_strobe),
    .busy       (busy)
);

// File: tb/oc_tag_ctrl_tb_top.sv
// Bench: directed scenarios, one task each, each checking its own results.
module oc_tag_ctrl_tb_top;
    localparam int INDEX_W = 9;
    localparam int LINES   = 1 << INDEX_W;
    localparam logic [31:0] MASK = 32'h1FFF_FC03;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                acc_req = 1'b0;
    logic                acc_we = 1'b0;
    logic                acc_assoc = 1'b0;
    logic [INDEX_W-1:0]  acc_line = '0;
    logic [31:0]         acc_wdata = '0;
    logic [31:0]         acc_rdata;
    logic                acc_ack;
    logic                wb_req;
    logic                wb_ack = 1'b0;
    logic [31:0]         wb_addr;
    logic [INDEX_W-1:0]  wb_index;
    logic                inv_strobe = 1'b0;
    logic                busy;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    bit  wb_seen  = 1'b0;

    oc_tag_ctrl #(.INDEX_W(INDEX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_assoc(acc_assoc), .acc_line(acc_line), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_ack(acc_ack), .wb_req(wb_req),
        .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_index(wb_index),
        .inv_strobe(inv_strobe), .busy(busy)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (wb_req) wb_seen = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One access with no write-back expected; returns read data.
    task automatic access(input logic we, input logic assoc, input int idx,
                          input logic [31:0] wd, output logic [31:0] rd);
        int guard = 0;
        acc_we    = we;
        acc_assoc = assoc;
        acc_line  = INDEX_W'(idx);
        acc_wdata = wd;
        acc_req   = 1'b1;
        do begin
            @(negedge clk);
            guard++;
        end while (!acc_ack && guard < 2000);
        rd      = acc_rdata;
        acc_req = 1'b0;
        @(negedge clk);
        check("R10 ack single cycle", {31'b0, acc_ack}, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        check("R9 busy after reset", {31'b0, busy}, 32'h0);
        check("R9 wb_req after reset", {31'b0, wb_req}, 32'h0);
        check("R9 ack after reset", {31'b0, acc_ack}, 32'h0);
        access(1'b0, 1'b0, 0, 32'h0, rd);
        check("R9 line 0 flags", {30'b0, rd[1:0]}, 32'h0);
        access(1'b0, 1'b0, LINES-1, 32'h0, rd);
        check("R9 last line flags", {30'b0, rd[1:0]}, 32'h0);
    endtask

    task automatic t_rw_mask();
        logic [31:0] rd;
        access(1'b1, 1'b0, 5, 32'hFFFF_FFFF, rd);
        access(1'b1, 1'b0, LINES-1, 32'h1234_5678, rd);
        access(1'b1, 1'b0, 6, 32'hE000_03FC, rd);
        access(1'b0, 1'b0, 5, 32'h0, rd);
        check("R2 all-ones masked", rd, 32'hFFFF_FFFF & MASK);
        access(1'b0, 1'b0, LINES-1, 32'h0, rd);
        check("R1 R2 last line", rd, 32'h1234_5678 & MASK);
        access(1'b0, 1'b0, 6, 32'h0, rd);
        check("R2 masked-out bits zero", rd, 32'h0);
        access(1'b0, 1'b0, 4, 32'h0, rd);
        check("R1 neighbour untouched", {30'b0, rd[1:0]}, 32'h0);
    endtask

    task automatic t_direct_over_dirty();
        logic [31:0] rd;
        access(1'b1, 1'b0, 7, 32'h0AAA_A403, rd);
        wb_seen = 1'b0;
        access(1'b1, 1'b0, 7, 32'h0555_5801, rd);
        check("R3 no write-back on direct write", {31'b0, wb_seen}, 32'h0);
        access(1'b0, 1'b0, 7, 32'h0, rd);
        check("R3 direct write stored", rd, 32'h0555_5801 & MASK);
    endtask

    task automatic t_assoc_dirty();
        logic [31:0] rd;
        int guard = 0;
        access(1'b1, 1'b0, 298, 32'h0ABC_D403, rd);
        acc_we = 1'b1; acc_assoc = 1'b1; acc_line = INDEX_W'(298);
        acc_wdata = 32'h0000_1401; acc_req = 1'b1;
        do begin
            @(negedge clk);
            guard++;
        end while (!wb_req && guard < 50);
        check("R4 wb_req raised", {31'b0, wb_req}, 32'h1);
        check("R4 wb_addr", wb_addr, 32'h0ABC_D400 | ((298 % 32) << 5));
        check("R4 wb_index", {23'b0, wb_index}, 32'd298);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 ack held during write-back", {31'b0, acc_ack}, 32'h0);
            check("R4 wb_req held", {31'b0, wb_req}, 32'h1);
        end
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        check("R5 ack after wb_ack", {31'b0, acc_ack}, 32'h1);
        check("R5 wb_req dropped", {31'b0, wb_req}, 32'h0);
        acc_req = 1'b0;
        @(negedge clk);
        access(1'b0, 1'b0, 298, 32'h0, rd);
        check("R5 new tag stored", rd, 32'h0000_1401);
    endtask

    task automatic t_assoc_clean();
        logic [31:0] rd;
        access(1'b1, 1'b0, 9, 32'h0100_0001, rd);
        access(1'b1, 1'b0, 10, 32'h0200_0002, rd);
        wb_seen = 1'b0;
        access(1'b1, 1'b1, 9, 32'h0300_0003, rd);
        access(1'b1, 1'b1, 10, 32'h0400_0001, rd);
        access(1'b1, 1'b1, 11, 32'h0500_0003, rd);
        check("R6 no write-back for non-dirty victims", {31'b0, wb_seen}, 32'h0);
        access(1'b0, 1'b0, 9, 32'h0, rd);
        check("R6 valid-only line replaced", rd, 32'h0300_0003);
        access(1'b0, 1'b0, 10, 32'h0, rd);
        check("R6 dirty-only line replaced", rd, 32'h0400_0001);
    endtask

    task automatic t_invalidate();
        logic [31:0] rd;
        int busy_cycles = 0;
        access(1'b1, 1'b0, 20, 32'h0777_7C03, rd);
        access(1'b1, 1'b0, LINES-2, 32'h0123_4401, rd);
        wb_seen = 1'b0;
        inv_strobe = 1'b1;
        @(negedge clk);
        inv_strobe = 1'b0;
        while (busy && busy_cycles < 5000) begin
            busy_cycles++;
            @(negedge clk);
        end
        check("R8 busy length", busy_cycles, LINES + 1);
        check("R7 no write-back on invalidate", {31'b0, wb_seen}, 32'h0);
        access(1'b0, 1'b0, 20, 32'h0, rd);
        check("R7 flags cleared, tag kept", rd, 32'h0777_7C00);
        access(1'b0, 1'b0, LINES-2, 32'h0, rd);
        check("R7 second line cleared", rd, 32'h0123_4400);
        access(1'b0, 1'b0, 5, 32'h0, rd);
        check("R7 line 5 flags", {30'b0, rd[1:0]}, 32'h0);
    endtask

    task automatic t_stall();
        logic [31:0] rd;
        int waited = 0;
        access(1'b1, 1'b0, 30, 32'h0999_9C01, rd);
        inv_strobe = 1'b1;
        @(negedge clk);
        inv_strobe = 1'b0;
        acc_we = 1'b0; acc_assoc = 1'b0; acc_line = INDEX_W'(30); acc_req = 1'b1;
        do begin
            @(negedge clk);
            waited++;
        end while (!acc_ack && waited < 5000);
        rd = acc_rdata;
        check("R8 ack only after walk", {31'b0, busy}, 32'h0);
        check("R8 stall length", {31'b0, waited > LINES}, 32'h1);
        check("R8 read after walk sees cleared line", rd, 32'h0999_9C00);
        acc_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw_mask();
        t_direct_over_dirty();
        t_assoc_dirty();
        t_assoc_clean();
        t_invalidate();
        t_stall();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule